// File: doc/BRIEF.md
# RTC Alarm and Status Unit

This block keeps a 32-bit seconds count for a real-time clock and raises an alarm when that count reaches a value that software has programmed. A slow square wave on `tick_in` (nominally 1 Hz) is sampled by the system clock through a two-flop synchronizer. Each rising edge of that wave becomes a one-cycle internal pulse. The pulse advances the counter, sets a sticky "second elapsed" flag and triggers a single comparison against the alarm register.

Software reaches three 32-bit registers through a simple single-cycle write and combinational read port. The registers are the counter, the alarm value, and a status/control word. The status/control word holds two sticky event flags, which software clears by writing ones to them, and an enable bit for each flag. Each flag ANDed with its enable drives a level interrupt request for an external interrupt controller. The request stays high until software clears the flag.

Top module: `rtc_alarm_unit`

## Requirements
- R1: After reset, the counter, alarm and status registers all read 0, and both `alarm_irq` and `hz_irq` are low.
- R2: Each rising edge of `tick_in` adds exactly one to the counter. The new value is readable by the fourth clock edge after `tick_in` rises, counting from the clock edge that first samples it. A falling edge of `tick_in` leaves the counter unchanged.
- R3: Every rising edge of `tick_in` sets the 1-Hz flag, which is status bit 1. A falling edge of `tick_in` does not set it.
- R4: On a tick, the alarm flag (status bit 0) is set if two conditions hold. The value the counter takes on that tick must equal the alarm register, and the alarm enable (status bit 2) must already be 1 before that cycle. Neither a match with the enable at 0 nor a mismatch sets the flag.
- R5: Writing 1 to status bit 0 or bit 1 clears that flag. Writing 0 to it leaves the flag unchanged.
- R6: If a tick sets a flag in the same cycle that a write of 1 clears it, the flag ends up 1.
- R7: Status bit 2 (alarm enable) and bit 3 (1-Hz enable) read back exactly as last written. Bits 31..4 of the status word always read 0, whatever was written.
- R8: `alarm_irq` is high exactly when status bits 0 and 2 are both 1. `hz_irq` is high exactly when status bits 1 and 3 are both 1.
- R9: Address 0 selects the counter and address 1 selects the alarm register. Both are fully readable and writable. Address 2 selects the status word. Address 3 reads 0, and writes to it change nothing.
- R10: A tick with the counter at 0xFFFFFFFF wraps the counter to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_in | input | 1 | Slow 1-Hz square wave, sampled by `clk` |
| wr_en | input | 1 | Register write strobe for one cycle |
| addr | input | 2 | Register select: 0 counter, 1 alarm, 2 status, 3 unused |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr`, combinational |
| alarm_irq | output | 1 | Alarm interrupt request, level |
| hz_irq | output | 1 | 1-Hz interrupt request, level |

## Verification
Two functions can coincide in one clock cycle: the tick pulse that sets the flags, and a software write of ones that clears them. The bench provokes this by raising `tick_in` and then issuing the clearing status write so that it is sampled on the same clock edge at which the synchronized pulse takes effect. For the alarm flag, the alarm register is preloaded to the counter's next value and the enable is on. Both flags are then read back and must be 1, because the set takes priority.

// File: rtl/rtc_pkg.sv
// Package: shared register selectors and status bit positions for the RTC
// alarm unit. Assumes a two-bit register select on the processor port.
package rtc_pkg;
    typedef enum logic [1:0] {
        REG_COUNT  = 2'd0,
        REG_ALARM  = 2'd1,
        REG_STATUS = 2'd2,
        REG_SPARE  = 2'd3
    } rtc_reg_e;

    localparam int ST_AL    = 0;   // alarm flag
    localparam int ST_HZ    = 1;   // 1-Hz flag
    localparam int ST_ALE   = 2;   // alarm enable
    localparam int ST_HZE   = 3;   // 1-Hz enable
    localparam int ST_BITS  = 4;   // implemented status bits
    localparam int FLAG_N   = 2;   // number of event flags
endpackage

// File: rtl/rtc_tick_sync.sv
// Module: rtc_tick_sync
// Samples the slow tick input through SYNC_STAGES flops and emits a
// one-cycle pulse on each rising edge of the synchronized level.
// Assumes tick_in is low during reset and far slower than clk.
module rtc_tick_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    output logic tick_pulse
);
    localparam int SH_W = SYNC_STAGES + 1;

    logic [SH_W-1:0] sh_q;

    // Shift the raw input through the synchronizer and one history flop.
    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[SH_W-2:0], tick_in};
    end

    // Rising edge: synchronized level high, previous level low.
    always_comb tick_pulse = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
endmodule

// File: rtl/rtc_counter.sv
// Module: rtc_counter
// Seconds counter. A processor write takes priority over a tick increment.
// Exposes the value the counter will hold after this edge for the compare.
module rtc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt_q,
    output logic [CNT_W-1:0] cnt_next
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    // Choose the next count: write, increment (wrapping) or hold.
    always_comb begin
        if (wr)        cnt_next = wdata;
        else if (tick) cnt_next = cnt_q + ONE;
        else           cnt_next = cnt_q;
    end

    // Register the count.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_next;
    end
endmodule

// File: rtl/rtc_status.sv
// Module: rtc_status
// Sticky event flags with write-one-to-clear, their enables, the alarm
// compare and the interrupt requests. A set event beats a clear in the
// same cycle. The compare uses the enable value held before this cycle.
module rtc_status #(
    parameter int CNT_W = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        tick,
    input  logic [CNT_W-1:0]            cnt_next,
    input  logic [CNT_W-1:0]            alarm_q,
    input  logic                        wr,
    input  logic [rtc_pkg::ST_BITS-1:0] wdata,
    output logic [rtc_pkg::FLAG_N-1:0]  flag_q,
    output logic [rtc_pkg::FLAG_N-1:0]  en_q,
    output logic [rtc_pkg::FLAG_N-1:0]  irq
);
    import rtc_pkg::*;

    logic                match;
    logic [FLAG_N-1:0]   set_vec;
    logic [FLAG_N-1:0]   clr_vec;

    // Alarm match is evaluated only on a tick and only with the enable on.
    always_comb match = tick & en_q[ST_AL] & (cnt_next == alarm_q);

    // Collect set and clear requests per flag.
    always_comb begin
        set_vec[ST_AL] = match;
        set_vec[ST_HZ] = tick;
        clr_vec        = {FLAG_N{wr}} & wdata[FLAG_N-1:0];
    end

    for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
        // Sticky flag: set wins, then write-one-to-clear.
        always_ff @(posedge clk) begin
            if (!rst_n)          flag_q[i] <= 1'b0;
            else if (set_vec[i]) flag_q[i] <= 1'b1;
            else if (clr_vec[i]) flag_q[i] <= 1'b0;
        end

        // Level request from flag and its enable.
        always_comb irq[i] = flag_q[i] & en_q[i];
    end

    // Enable bits load directly from ordinary status writes.
    always_ff @(posedge clk) begin
        if (!rst_n)  en_q <= '0;
        else if (wr) en_q <= wdata[ST_HZE:ST_ALE];
    end
endmodule

// File: rtl/rtc_alarm_unit.sv
// Module: rtc_alarm_unit (top)
// RTC seconds counter, alarm register and status/control word behind a
// single-cycle write, combinational read port. Assumes tick_in is a slow
// level, low during reset; it is synchronized here.
module rtc_alarm_unit #(
    parameter int DATA_W      = 32,
    parameter int ADDR_W      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              alarm_irq,
    output logic              hz_irq
);
    import rtc_pkg::*;

    logic                tick_pulse;
    logic                wr_cnt, wr_alarm, wr_status;
    logic [DATA_W-1:0]   cnt_q, cnt_next, alarm_q;
    logic [FLAG_N-1:0]   flag_q, en_q, irq;
    logic                al_flag, hz_flag, al_en;

    // Decode the write strobe per register.
    always_comb begin
        wr_cnt    = wr_en && (addr == ADDR_W'(REG_COUNT));
        wr_alarm  = wr_en && (addr == ADDR_W'(REG_ALARM));
        wr_status = wr_en && (addr == ADDR_W'(REG_STATUS));
    end

    rtc_tick_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .tick_pulse(tick_pulse)
    );

    rtc_counter #(.CNT_W(DATA_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick_pulse), .wr(wr_cnt),
        .wdata(wdata), .cnt_q(cnt_q), .cnt_next(cnt_next)
    );

    // Alarm compare register, reset to 0 for determinism.
    always_ff @(posedge clk) begin
        if (!rst_n)        alarm_q <= '0;
        else if (wr_alarm) alarm_q <= wdata;
    end

    rtc_status #(.CNT_W(DATA_W)) u_status (
        .clk(clk), .rst_n(rst_n), .tick(tick_pulse), .cnt_next(cnt_next),
        .alarm_q(alarm_q), .wr(wr_status), .wdata(wdata[ST_BITS-1:0]),
        .flag_q(flag_q), .en_q(en_q), .irq(irq)
    );

    // Name the status fields and route the requests out.
    always_comb begin
        al_flag   = flag_q[ST_AL];
        hz_flag   = flag_q[ST_HZ];
        al_en     = en_q[ST_AL];
        alarm_irq = irq[ST_AL];
        hz_irq    = irq[ST_HZ];
    end

    // Read mux; reserved status bits and the spare address read 0.
    always_comb begin
        rdata = '0;
        case (addr)
            ADDR_W'(REG_COUNT):  rdata = cnt_q;
            ADDR_W'(REG_ALARM):  rdata = alarm_q;
            ADDR_W'(REG_STATUS): rdata[ST_BITS-1:0] = {en_q, flag_q};
            default:             rdata = '0;
        endcase
    end
endmodule

// File: rtl/rtc_alarm_unit_chk.sv
// Module: rtc_alarm_unit_chk
// Property checker for rtc_alarm_unit, attached by bind below.
module rtc_alarm_unit_chk #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic              tick_pulse,
    input logic [DATA_W-1:0] cnt_q,
    input logic              al_flag,
    input logic              hz_flag,
    input logic              al_en
);
    logic cnt_wr, st_wr;
    always_comb begin
        cnt_wr = wr_en && (addr == ADDR_W'(0));
        st_wr  = wr_en && (addr == ADDR_W'(2));
    end

    // R2: one tick advances the count by exactly one.
    assert_cnt_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        tick_pulse && !cnt_wr |=> cnt_q == $past(cnt_q) + DATA_W'(1));

    // R2: without tick or write the count holds.
    assert_cnt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_pulse && !cnt_wr |=> $stable(cnt_q));

    // R3: a tick always leaves the 1-Hz flag set.
    assert_hz_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_pulse |=> hz_flag);

    // R4: alarm flag cannot rise while its enable was off.
    assert_al_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !al_en |=> !$rose(al_flag));

    // R4: alarm flag rises only as a result of a tick.
    assert_al_on_tick_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(al_flag) |-> $past(tick_pulse));

    // R5: write of one clears the 1-Hz flag when no tick competes.
    assert_hz_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        st_wr && wdata[1] && !tick_pulse |=> !hz_flag);

    // R7: reserved status bits read zero.
    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        addr == ADDR_W'(2) |-> rdata[DATA_W-1:4] == '0);
endmodule

bind rtc_alarm_unit rtc_alarm_unit_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tick_pulse(tick_pulse), .cnt_q(cnt_q),
    .al_flag(al_flag), .hz_flag(hz_flag), .al_en(al_en)
);

// File: tb/tb_rtc_alarm_unit.sv
`timescale 1ns/1ps
module tb_rtc_alarm_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  addr = 2'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        alarm_irq, hz_irq;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] v, c;

    rtc_alarm_unit dut (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_in), .wr_en(wr_en),
        .addr(addr), .wdata(wdata), .rdata(rdata),
        .alarm_irq(alarm_irq), .hz_irq(hz_irq)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic tick_rise();
        @(negedge clk); tick_in = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic tick_fall();
        @(negedge clk); tick_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        reg_rd(2'd0, v); chk("R1 counter", v, 32'h0);
        reg_rd(2'd1, v); chk("R1 alarm", v, 32'h0);
        reg_rd(2'd2, v); chk("R1 status", v, 32'h0);
        chk("R1 irqs", {30'd0, alarm_irq, hz_irq}, 32'h0);
    endtask

    task automatic t_regs();
        reg_wr(2'd0, 32'h1234_5678); reg_rd(2'd0, v); chk("R9 counter rw", v, 32'h1234_5678);
        reg_wr(2'd1, 32'hCAFE_0001); reg_rd(2'd1, v); chk("R9 alarm rw", v, 32'hCAFE_0001);
        reg_wr(2'd3, 32'hFFFF_FFFF);
        reg_rd(2'd3, v); chk("R9 spare reads 0", v, 32'h0);
        reg_rd(2'd0, v); chk("R9 spare write ignored cnt", v, 32'h1234_5678);
        reg_rd(2'd1, v); chk("R9 spare write ignored alarm", v, 32'hCAFE_0001);
        reg_rd(2'd2, v); chk("R9 spare write ignored status", v, 32'h0);
    endtask

    task automatic t_status_bits();
        reg_wr(2'd2, 32'hFFFF_FFF8); reg_rd(2'd2, v); chk("R7 reserved 0, HZE only", v, 32'h8);
        reg_wr(2'd2, 32'h0000_0004); reg_rd(2'd2, v); chk("R7 ALE only", v, 32'h4);
        reg_wr(2'd2, 32'h0); reg_rd(2'd2, v); chk("R7 enables off", v, 32'h0);
    endtask

    task automatic t_tick();
        reg_wr(2'd0, 32'd100);
        tick_rise();
        reg_rd(2'd0, v); chk("R2 increment", v, 32'd101);
        reg_rd(2'd2, v); chk("R3 hz flag set", v & 32'h2, 32'h2);
        chk("R8 hz_irq off when HZE 0", {31'd0, hz_irq}, 32'h0);
        reg_wr(2'd2, 32'h0000_0008); reg_rd(2'd2, v); chk("R5 write 0 keeps hz", v, 32'hA);
        chk("R8 hz_irq on", {31'd0, hz_irq}, 32'h1);
        reg_wr(2'd2, 32'h0000_000A); reg_rd(2'd2, v); chk("R5 write 1 clears hz", v, 32'h8);
        chk("R8 hz_irq drops", {31'd0, hz_irq}, 32'h0);
        tick_fall();
        reg_rd(2'd0, v); chk("R2 fall no increment", v, 32'd101);
        reg_rd(2'd2, v); chk("R3 fall no hz flag", v, 32'h8);
        reg_wr(2'd2, 32'h0);
    endtask

    task automatic t_alarm();
        reg_rd(2'd0, c);
        reg_wr(2'd1, c + 32'd1); reg_wr(2'd2, 32'h4);
        tick_rise();
        reg_rd(2'd2, v); chk("R4 alarm on match+enable", v & 32'h1, 32'h1);
        chk("R8 alarm_irq", {30'd0, alarm_irq, hz_irq}, 32'h2);
        reg_wr(2'd2, 32'h5); reg_rd(2'd2, v); chk("R5 alarm clear", v & 32'h1, 32'h0);
        chk("R8 alarm_irq drops", {31'd0, alarm_irq}, 32'h0);
        tick_fall();
        // match with enable off
        reg_wr(2'd2, 32'h3);
        reg_rd(2'd0, c); reg_wr(2'd1, c + 32'd1);
        tick_rise();
        reg_rd(2'd2, v); chk("R4 no alarm enable off", v & 32'h1, 32'h0);
        tick_fall();
        // mismatch with enable on
        reg_wr(2'd2, 32'h7);
        reg_rd(2'd0, c); reg_wr(2'd1, c + 32'd5);
        tick_rise();
        reg_rd(2'd2, v); chk("R4 no alarm on mismatch", v & 32'h1, 32'h0);
        tick_fall();
        reg_wr(2'd2, 32'h3);
    endtask

    task automatic t_set_wins();
        tick_rise(); tick_fall();              // hz flag now 1
        reg_rd(2'd0, c); reg_wr(2'd1, c + 32'd1); reg_wr(2'd2, 32'h4);
        @(negedge clk); tick_in = 1'b1;
        @(negedge clk);                         // after first sampling edge
        @(negedge clk);                         // pulse cycle
        addr = 2'd2; wdata = 32'h7; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
        reg_rd(2'd2, v); chk("R6 set beats clear", v, 32'h7);
        tick_fall();
        reg_wr(2'd2, 32'h3);
    endtask

    task automatic t_wrap();
        reg_wr(2'd0, 32'hFFFF_FFFF);
        tick_rise();
        reg_rd(2'd0, v); chk("R10 wrap to zero", v, 32'h0);
        tick_fall();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_status_bits();
        t_tick();
        t_alarm();
        t_set_wins();
        t_wrap();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule